// File: doc/BRIEF.md
# Shared Cache Maintenance Command Queue

This block is the register-mapped front end of a shared cache maintenance engine. Several requesters (CPUs) reach it over one simple register bus that carries a requester identifier with every access. A requester builds a command in a shared set of command registers: an operation (invalidate, clean or flush), a scope (an address range or the whole cache), an optional completion notice and, for range commands, a start address and a size. The hardware grants the shared command registers to one requester at a time. The first write to the mode register takes ownership. Reading the registration status register gives ownership back and commits the command.

Committed commands wait in a FIFO. A downstream executor takes them one at a time over a valid/ready handshake and signals the end of each command with a done pulse. Each requester has its own status bank. That bank reports whether its last registration was accepted, whether any of its commands are queued or executing, and whether a command that asked for notification has finished. A separate primitive register arms a drain. A read of that register only returns once the queue is empty and the executor is idle.

Top module: `cmq_top`

## Requirements
- R1: Register word addresses are: 0 mode, 1 start address, 2 size, 3 registration status, 4 queue status, 5 primitive. In the mode word, bits [1:0] carry the operation (0 invalidate, 1 clean, 2 flush), bits [18:17] carry the scope (0 range, 1 whole cache) and bit 15 requests notification. The operation and scope appear on cmd_op and cmd_whole when the command is issued.
- R2: A range command carries the start and size register values on cmd_start and cmd_size. A whole-cache command presents zero on both, whatever was written to those registers.
- R3: When no requester owns the command registers, a write to the mode register makes the writer the owner. While an owner exists, writes from any other requester to mode, start or size have no effect. A registration-status read by a non-owner returns 1 (bit 0, failed).
- R4: When the owner reads registration status, ownership is released. The read returns 0 and enqueues the command if the queue has room. It returns 2 (bit 1, full) and discards the command if the queue is full. It returns 1 and discards the command if the scope is not 0 or 1.
- R5: Commands are issued in the order they were registered. cmd_valid stays high with stable fields until cmd_ready. No new command is offered until the executing one has signalled cmd_done.
- R6: A queue status read returns that requester's own bits: bit 0 is set while any of its commands is queued, bit 1 while one of its commands is executing, and bit 2 is the completion flag.
- R7: cmd_done sets the completion flag of the requester that issued the command, and only when notification was requested. Writing queue status with bit 2 set clears the writer's flag. A write with bit 2 clear leaves the flag unchanged.
- R8: Writing 8 (drain) or 9 (prefetch flush) to the primitive register arms a drain. A primitive read while armed returns 0 only once the queue is empty and no command is executing. Other codes do not arm, and the read then answers at the normal latency.
- R9: Every read other than an armed primitive read returns bus_rvalid with its data exactly one clock after the request. Reads of addresses without a status meaning return 0.
- R10: After reset there is no owner, the queue is empty, cmd_valid is low and every requester's queue status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_id | input | IDW | Requester identifier |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | DW | Write data |
| bus_rvalid | output | 1 | Read response valid |
| bus_rdata | output | DW | Read response data |
| cmd_valid | output | 1 | Command offered to executor |
| cmd_ready | input | 1 | Executor accepts the command |
| cmd_req_id | output | IDW | Issuing requester |
| cmd_op | output | 2 | Operation code |
| cmd_whole | output | 1 | Whole-cache scope |
| cmd_start | output | AW | Range start address |
| cmd_size | output | AW | Range size |
| cmd_done | input | 1 | Executor finished current command |

## Verification
Each read response is registered once, so the bench samples it at the first falling edge after the request edge and also checks that no further edge was needed. A registration commits at the status-read edge, so the queued bit is due on the very next read. An executor accept shows as the executing bit one edge later. A done pulse sets the completion flag at the edge that samples it. The armed drain read is the only response whose timing is open-ended. The bench watches for its absence edge by edge while a command is outstanding and then for its arrival within a few edges after the done pulse.

// File: rtl/cmq_pkg.sv
package cmq_pkg;
  typedef enum logic [2:0] {
    REG_MODE    = 3'd0,
    REG_START   = 3'd1,
    REG_SIZE    = 3'd2,
    REG_SETSTAT = 3'd3,
    REG_QSTAT   = 3'd4,
    REG_PRIM    = 3'd5
  } reg_idx_t;

  localparam int MODE_OP_LO    = 0;
  localparam int MODE_NOTIFY   = 15;
  localparam int MODE_SCOPE_LO = 17;

  localparam logic [1:0] SCOPE_RANGE = 2'd0;
  localparam logic [1:0] SCOPE_ALL   = 2'd1;

  localparam logic [1:0] SET_OK    = 2'd0;
  localparam logic [1:0] SET_FAIL  = 2'd1;
  localparam logic [1:0] SET_FULL  = 2'd2;

  localparam int QS_DONE = 2;

  localparam logic [3:0] PRIM_DRAIN  = 4'h8;
  localparam logic [3:0] PRIM_PFLUSH = 4'h9;
endpackage

// File: rtl/cmq_fifo.sv
module cmq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end

  assign dout  = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/cmq_tracker.sv
module cmq_tracker #(
  parameter int NREQ = 4,
  parameter int IDW  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            launch,
  input  logic [IDW-1:0]  launch_id,
  input  logic            launch_notify,
  input  logic            fin,
  input  logic            clr_valid,
  input  logic [IDW-1:0]  clr_id,
  output logic            busy,
  output logic [IDW-1:0]  cur_id,
  output logic            cur_notify,
  output logic [NREQ-1:0] done_flags
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      cur_id     <= '0;
      cur_notify <= 1'b0;
    end else if (launch) begin
      busy       <= 1'b1;
      cur_id     <= launch_id;
      cur_notify <= launch_notify;
    end else if (fin) begin
      busy       <= 1'b0;
    end
  end

  for (genvar r = 0; r < NREQ; r++) begin : g_flag
    logic flag_q;
    wire  set_r = fin && busy && cur_notify && (cur_id == IDW'(r));
    wire  clr_r = clr_valid && (clr_id == IDW'(r));
    always_ff @(posedge clk) begin
      if (rst)        flag_q <= 1'b0;
      else if (set_r) flag_q <= 1'b1;
      else if (clr_r) flag_q <= 1'b0;
    end
    assign done_flags[r] = flag_q;
  end
endmodule

// File: rtl/cmq_top.sv
module cmq_top
  import cmq_pkg::*;
#(
  parameter int NREQ  = 4,
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IDW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_valid,
  input  logic           bus_write,
  input  logic [IDW-1:0] bus_id,
  input  logic [2:0]     bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic           bus_rvalid,
  output logic [DW-1:0]  bus_rdata,
  output logic           cmd_valid,
  input  logic           cmd_ready,
  output logic [IDW-1:0] cmd_req_id,
  output logic [1:0]     cmd_op,
  output logic           cmd_whole,
  output logic [AW-1:0]  cmd_start,
  output logic [AW-1:0]  cmd_size,
  input  logic           cmd_done
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = IDW + 1 + 2 + 1 + 2 * AW;

  logic           own_vld;
  logic [IDW-1:0] own_id;
  logic [1:0]     m_op, m_scope;
  logic           m_notify;
  logic [AW-1:0]  m_start, m_size;
  logic           drain_armed, drain_wait;

  logic           fifo_empty, fifo_full, push, pop;
  logic [EW-1:0]  push_ent, head_ent;
  logic           h_notify;
  logic           busy, cur_notify;
  logic [IDW-1:0] cur_id;
  logic [NREQ-1:0] done_flags, queued_v;

  wire      acc_wr   = bus_valid && bus_write;
  wire      acc_rd   = bus_valid && !bus_write;
  wire      is_owner = own_vld && (own_id == bus_id);
  reg_idx_t ridx;
  assign    ridx     = reg_idx_t'(bus_addr);
  wire      sc_ok    = (m_scope == SCOPE_RANGE) || (m_scope == SCOPE_ALL);
  wire      whole    = (m_scope == SCOPE_ALL);
  wire      prim_arm = (bus_wdata[3:0] == PRIM_DRAIN) || (bus_wdata[3:0] == PRIM_PFLUSH);

  assign push     = acc_rd && (ridx == REG_SETSTAT) && is_owner && sc_ok && !fifo_full;
  assign push_ent = {bus_id, m_notify, m_op, whole,
                     whole ? '0 : m_start, whole ? '0 : m_size};
  assign {cmd_req_id, h_notify, cmd_op, cmd_whole, cmd_start, cmd_size} = head_ent;
  assign cmd_valid = !fifo_empty && !busy;
  assign pop       = cmd_valid && cmd_ready;

  cmq_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din(push_ent), .pop(pop),
    .dout(head_ent), .empty(fifo_empty), .full(fifo_full)
  );

  cmq_tracker #(.NREQ(NREQ), .IDW(IDW)) u_track (
    .clk(clk), .rst(rst), .launch(pop), .launch_id(cmd_req_id),
    .launch_notify(h_notify), .fin(cmd_done),
    .clr_valid(acc_wr && (ridx == REG_QSTAT) && bus_wdata[QS_DONE]),
    .clr_id(bus_id), .busy(busy), .cur_id(cur_id),
    .cur_notify(cur_notify), .done_flags(done_flags)
  );

  // per-requester count of commands still waiting in the queue
  for (genvar r = 0; r < NREQ; r++) begin : g_pend
    logic [CW-1:0] cnt;
    wire inc = push && (bus_id == IDW'(r));
    wire dec = pop && (cmd_req_id == IDW'(r));
    always_ff @(posedge clk) begin
      if (rst)              cnt <= '0;
      else if (inc && !dec) cnt <= cnt + CW'(1);
      else if (dec && !inc) cnt <= cnt - CW'(1);
    end
    assign queued_v[r] = (cnt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_vld     <= 1'b0;
      own_id      <= '0;
      m_op        <= '0;
      m_scope     <= '0;
      m_notify    <= 1'b0;
      m_start     <= '0;
      m_size      <= '0;
      drain_armed <= 1'b0;
      drain_wait  <= 1'b0;
      bus_rvalid  <= 1'b0;
      bus_rdata   <= '0;
    end else begin
      bus_rvalid <= 1'b0;
      if (acc_wr) begin
        case (ridx)
          REG_MODE: if (!own_vld || is_owner) begin
            own_vld  <= 1'b1;
            own_id   <= bus_id;
            m_op     <= bus_wdata[MODE_OP_LO +: 2];
            m_scope  <= bus_wdata[MODE_SCOPE_LO +: 2];
            m_notify <= bus_wdata[MODE_NOTIFY];
          end
          REG_START: if (is_owner) m_start <= bus_wdata[AW-1:0];
          REG_SIZE:  if (is_owner) m_size  <= bus_wdata[AW-1:0];
          REG_PRIM:  if (prim_arm) drain_armed <= 1'b1;
          default: ;
        endcase
      end
      if (acc_rd) begin
        case (ridx)
          REG_SETSTAT: begin
            bus_rvalid <= 1'b1;
            if (is_owner) begin
              own_vld   <= 1'b0;
              bus_rdata <= DW'(!sc_ok ? SET_FAIL : (fifo_full ? SET_FULL : SET_OK));
            end else begin
              bus_rdata <= DW'(SET_FAIL);
            end
          end
          REG_QSTAT: begin
            bus_rvalid <= 1'b1;
            bus_rdata  <= DW'({done_flags[bus_id], busy && (cur_id == bus_id),
                               queued_v[bus_id]});
          end
          REG_PRIM: begin
            if (drain_armed) drain_wait <= 1'b1;
            else begin
              bus_rvalid <= 1'b1;
              bus_rdata  <= '0;
            end
          end
          default: begin
            bus_rvalid <= 1'b1;
            bus_rdata  <= '0;
          end
        endcase
      end
      if (drain_wait && fifo_empty && !busy) begin
        drain_wait  <= 1'b0;
        drain_armed <= 1'b0;
        bus_rvalid  <= 1'b1;
        bus_rdata   <= '0;
      end
    end
  end
endmodule

// File: rtl/cmq_chk.sv
module cmq_chk #(
  parameter int NREQ = 4,
  parameter int IDW  = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_valid,
  input logic            bus_write,
  input logic [IDW-1:0]  bus_id,
  input logic [2:0]      bus_addr,
  input logic            bus_rvalid,
  input logic            own_vld,
  input logic [IDW-1:0]  own_id,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [IDW-1:0]  cmd_req_id,
  input logic            cmd_done,
  input logic            busy,
  input logic [IDW-1:0]  cur_id,
  input logic            cur_notify,
  input logic [NREQ-1:0] done_flags,
  input logic            drain_wait,
  input logic            fifo_empty
);
  // R3
  non_owner_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_write && bus_addr == 3'd0 && own_vld && bus_id != own_id
    |=> own_vld && own_id == $past(own_id));

  // R4
  release_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_write && bus_addr == 3'd3 && own_vld && bus_id == own_id
    |=> !own_vld);

  // R5
  offer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_req_id));

  // R5
  single_exec_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready |=> busy && !cmd_valid);

  // R7
  notify_chk: assert property (@(posedge clk) disable iff (rst)
    busy && cmd_done && cur_notify |=> done_flags[$past(cur_id)]);

  // R8
  drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    drain_wait && !(fifo_empty && !busy) |=> drain_wait && !bus_rvalid);
endmodule

bind cmq_top cmq_chk #(.NREQ(NREQ), .IDW(IDW)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_id(bus_id), .bus_addr(bus_addr), .bus_rvalid(bus_rvalid),
  .own_vld(own_vld), .own_id(own_id), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_req_id(cmd_req_id), .cmd_done(cmd_done),
  .busy(busy), .cur_id(cur_id), .cur_notify(cur_notify),
  .done_flags(done_flags), .drain_wait(drain_wait), .fifo_empty(fifo_empty)
);

// File: tb/cmq_top_tb.sv
module cmq_top_tb;
  localparam int NREQ = 4, DEPTH = 4, AW = 32, DW = 32, IDW = 2;
  localparam int A_MODE = 0, A_START = 1, A_SIZE = 2, A_SET = 3, A_QS = 4, A_PRIM = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_valid = 0, bus_write = 0;
  logic [IDW-1:0] bus_id = '0;
  logic [2:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_rvalid;
  logic [DW-1:0] bus_rdata;
  logic cmd_valid, cmd_ready = 0, cmd_whole, cmd_done = 0;
  logic [IDW-1:0] cmd_req_id;
  logic [1:0] cmd_op;
  logic [AW-1:0] cmd_start, cmd_size;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [IDW-1:0] t_id; logic [1:0] t_op; logic t_whole, t_ok;
  logic [AW-1:0] t_start, t_size;

  always #2 clk = ~clk;

  cmq_top #(.NREQ(NREQ), .DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_id(bus_id), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_req_id(cmd_req_id), .cmd_op(cmd_op),
    .cmd_whole(cmd_whole), .cmd_start(cmd_start), .cmd_size(cmd_size),
    .cmd_done(cmd_done)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int id, input int a, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_id = IDW'(id); bus_addr = 3'(a); bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input int id, input int a, output logic [31:0] d, output int waits);
    bus_valid = 1; bus_write = 0; bus_id = IDW'(id); bus_addr = 3'(a);
    @(negedge clk);
    bus_valid = 0;
    waits = 0;
    while (!bus_rvalid && waits < 40) begin @(negedge clk); waits++; end
    d = bus_rdata;
  endtask

  task automatic reg_cmd(input int id, input int op, input int scope, input bit ntf,
                         input logic [31:0] st, input logic [31:0] sz, output logic [31:0] res);
    int w;
    wr(id, A_MODE, (32'(scope) << 17) | (32'(ntf) << 15) | 32'(op));
    wr(id, A_START, st);
    wr(id, A_SIZE, sz);
    rd(id, A_SET, res, w);
  endtask

  task automatic take();
    int n = 0;
    while (!cmd_valid && n < 20) begin @(negedge clk); n++; end
    t_ok = cmd_valid; t_id = cmd_req_id; t_op = cmd_op; t_whole = cmd_whole;
    t_start = cmd_start; t_size = cmd_size;
    cmd_ready = 1; @(negedge clk); cmd_ready = 0;
  endtask

  task automatic finish_cmd();
    cmd_done = 1; @(negedge clk); cmd_done = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d; int w, k;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk("R10 cmd_valid", cmd_valid, 0);
    for (int id = 0; id < NREQ; id++) begin
      rd(id, A_QS, d, w);
      chk("R10 qstat", d, 0);
      chk("R9 latency", w, 0);
    end
    rd(0, A_SET, d, w);
    chk("R3 no owner fail", d, 1);
    rd(2, 7, d, w);
    chk("R9 unmapped", d, 0);

    // R1 R2 R4 R6 R7 sweep
    k = 0;
    for (int id = 0; id < NREQ; id++)
      for (int op = 0; op < 3; op++)
        for (int sc = 0; sc < 2; sc++)
          for (int nt = 0; nt < 2; nt++) begin
            logic [31:0] st, sz;
            st = 32'h0001_0000 + 32'(k) * 32'h40;
            sz = 32'h80 + 32'(k);
            reg_cmd(id, op, sc, nt[0], st, sz, d);
            chk("R4 accepted", d, 0);
            rd(id, A_QS, d, w);
            chk("R6 queued", d, 1);
            take();
            chk("R1 id", {t_ok, t_id}, {1'b1, IDW'(id)});
            chk("R1 op/scope", {t_op, t_whole}, {2'(op), sc[0]});
            chk("R2 start", t_start, sc ? 0 : st);
            chk("R2 size", t_size, sc ? 0 : sz);
            rd(id, A_QS, d, w);
            chk("R6 executing", d, 2);
            finish_cmd();
            rd(id, A_QS, d, w);
            chk("R7 flag", d, nt ? 4 : 0);
            rd((id + 1) % NREQ, A_QS, d, w);
            chk("R7 other bank", d, 0);
            wr(id, A_QS, 32'h3);
            rd(id, A_QS, d, w);
            chk("R7 no clear", d, nt ? 4 : 0);
            wr(id, A_QS, 32'h4);
            rd(id, A_QS, d, w);
            chk("R7 clear", d, 0);
            k++;
          end

    // R3 contention
    wr(0, A_MODE, 32'h1);
    wr(0, A_START, 32'hA000);
    wr(1, A_START, 32'hDEAD);
    wr(1, A_MODE, 32'h2);
    wr(0, A_SIZE, 32'h40);
    rd(1, A_SET, d, w);
    chk("R3 intruder fails", d, 1);
    rd(0, A_SET, d, w);
    chk("R3 owner ok", d, 0);
    take();
    chk("R3 owner cmd", {t_id, t_op, t_start, t_size}, {2'd0, 2'd1, 32'hA000, 32'h40});
    finish_cmd();
    reg_cmd(1, 2, 0, 0, 32'hB000, 32'h20, d);
    chk("R3 retry ok", d, 0);
    take();
    chk("R3 retry cmd", {t_id, t_op, t_start}, {2'd1, 2'd2, 32'hB000});
    finish_cmd();

    // R4 reserved scope
    reg_cmd(2, 0, 2, 0, 32'h0, 32'h0, d);
    chk("R4 bad scope", d, 1);
    @(negedge clk);
    chk("R4 bad scope no cmd", cmd_valid, 0);

    // R4 full, R5 order
    for (int i = 0; i < DEPTH; i++) begin
      reg_cmd(i % NREQ, i % 3, 0, 1, 32'h100 * 32'(i + 1), 32'h10, d);
      chk("R4 fill", d, 0);
    end
    reg_cmd(3, 0, 1, 0, 0, 0, d);
    chk("R4 full", d, 2);
    for (int i = 0; i < DEPTH; i++) begin
      take();
      chk("R5 order", {t_id, t_op, t_start}, {IDW'(i % NREQ), 2'(i % 3), 32'h100 * 32'(i + 1)});
      repeat (2) @(negedge clk);
      chk("R5 one at a time", cmd_valid, 0);
      finish_cmd();
      wr(i % NREQ, A_QS, 32'h4);
    end

    // R8 drain
    reg_cmd(1, 2, 0, 0, 32'h400, 32'h40, d);
    take();
    wr(1, A_PRIM, 32'h8);
    bus_valid = 1; bus_write = 0; bus_id = 2'd1; bus_addr = 3'(A_PRIM);
    @(negedge clk);
    bus_valid = 0;
    begin
      bit early = 0;
      for (int i = 0; i < 6; i++) begin
        if (bus_rvalid) early = 1;
        @(negedge clk);
      end
      chk("R8 no early reply", early, 0);
    end
    finish_cmd();
    begin
      int n = 0;
      while (!bus_rvalid && n < 10) begin @(negedge clk); n++; end
      chk("R8 drain reply", {bus_rvalid, bus_rdata}, {1'b1, 32'h0});
    end
    @(negedge clk);
    wr(0, A_PRIM, 32'h3);
    rd(0, A_PRIM, d, w);
    chk("R8 unarmed latency", w, 0);
    wr(0, A_PRIM, 32'h9);
    rd(0, A_PRIM, d, w);
    chk("R8 prefetch flush idle", (w <= 2) && (d == 0), 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule